// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block drives the system reset line of a supply supervisor. It takes two fault sources. The first is a supply-good level that an external comparator produces and that is already synchronized to the block clock. The second is a one-cycle watchdog timeout pulse. Either source makes the reset output active on the next clock edge. The output is released only after the supply has stayed good, with no watchdog timeout, for a full stretch window. Any fault inside the window starts the window again from zero.

The stretch window is `STRETCH_TICKS` ticks of a prescaler that divides the clock by `PRESCALE`. With a 1 kHz tick, 200 ticks give a 200 ms window. A testbench can make the window short by choosing small values. The output polarity is fixed at build time. A volatile cause flag records the source of the most recent reset: 1 for a watchdog timeout, 0 for a low supply or power-on reset. Two command strobes can set the flag or clear it.

Top module: `rst_pulse_gen`

## Requirements
- R1: While `supply_ok` is 0 at a rising clock edge, the internal reset state is active after that edge and stays active for as long as `supply_ok` stays 0.
- R2: After the last clock edge that sees a fault (`supply_ok`=0 or `wdog_to`=1), the reset stays active for exactly `PRESCALE*STRETCH_TICKS` further clock edges and is released on the last of them. A fault at any point in the window restarts the full count.
- R3: While `rst_n` is 0, the reset is active and `wd_flag` is 0. After `rst_n` rises with the supply good, the release comes on the `PRESCALE*STRETCH_TICKS`-th clock edge.
- R4: A one-cycle `wdog_to` pulse makes the reset active and starts the same stretched pulse as a supply fault.
- R5: With `ACTIVE_LOW`=1, active reset is `rst_out`=0. With `ACTIVE_LOW`=0, active reset is `rst_out`=1.
- R6: If no command is present, a clock edge with `wdog_to`=1 and `supply_ok`=1 sets `wd_flag` to 1. A clock edge with `supply_ok`=0 clears it to 0, and this holds even when `wdog_to` is also 1.
- R7: `flag_set`=1 at an edge makes `wd_flag` 1. `flag_clr`=1 without `flag_set` makes it 0. A command takes priority over both fault sources, and when both strobes are present `flag_set` wins.
- R8: `wd_flag` does not change at an edge with no command and no fault. In particular, the release of the reset leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset of the logic |
| supply_ok | input | 1 | Synchronized supply-above-trip indication, 1 = good |
| wdog_to | input | 1 | Watchdog timeout pulse, one cycle |
| flag_set | input | 1 | Command strobe: set the cause flag |
| flag_clr | input | 1 | Command strobe: clear the cause flag |
| rst_out | output | 1 | System reset, polarity set by `ACTIVE_LOW` |
| wd_flag | output | 1 | Cause flag, 1 = last reset came from the watchdog |

## Verification
A stretch counter that does not restart on a fault, or that wraps one tick early or late, shows at `rst_out` as a release on the wrong cycle. The bench finds this within one window by counting cycles after each fault. The bench moves a one-cycle dip and a watchdog pulse to every position inside the window and checks the exact release cycle each time. A wrong priority among the flag updates shows on `wd_flag` one edge after the conflicting strobes or faults.

// File: rtl/rst_pulse_gen.sv
module rst_pulse_gen #(
  parameter bit ACTIVE_LOW    = 1'b1,
  parameter int PRESCALE      = 1000,
  parameter int STRETCH_TICKS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic wdog_to,
  input  logic flag_set,
  input  logic flag_clr,
  output logic rst_out,
  output logic wd_flag
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int SW = (STRETCH_TICKS > 1) ? $clog2(STRETCH_TICKS) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);
  localparam logic [SW-1:0] STR_LAST = SW'(STRETCH_TICKS - 1);
  localparam logic ACT = ~ACTIVE_LOW;

  logic [PW-1:0] pre_cnt;
  logic [SW-1:0] str_cnt;
  logic          active;
  logic          fault, tick;

  assign fault = !supply_ok || wdog_to;
  assign tick  = (pre_cnt == PRE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      str_cnt <= '0;
      active  <= 1'b1;
    end else if (fault) begin
      pre_cnt <= '0;
      str_cnt <= '0;
      active  <= 1'b1;
    end else if (active) begin
      if (tick) begin
        pre_cnt <= '0;
        if (str_cnt == STR_LAST) begin
          str_cnt <= '0;
          active  <= 1'b0;
        end else begin
          str_cnt <= str_cnt + 1'b1;
        end
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          wd_flag <= 1'b0;
    else if (flag_set)   wd_flag <= 1'b1;
    else if (flag_clr)   wd_flag <= 1'b0;
    else if (!supply_ok) wd_flag <= 1'b0;
    else if (wdog_to)    wd_flag <= 1'b1;
  end

  assign rst_out = active ? ACT : ~ACT;

  // R1
  low_supply_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> rst_out == ACT);
  // R4
  wdog_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_to |=> rst_out == ACT);
  // R2
  clean_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_out == ACT) ##1 (rst_out != ACT) |-> $past(supply_ok) && !$past(wdog_to));
  // R2
  counter_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_cnt <= PRE_LAST) && (str_cnt <= STR_LAST));
  // R7
  set_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set |=> wd_flag);
  // R7
  clr_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && !flag_set |=> !wd_flag);
  // R6
  wdog_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_to && supply_ok && !flag_set && !flag_clr |=> wd_flag);
  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    supply_ok && !wdog_to && !flag_set && !flag_clr |=> $stable(wd_flag));
endmodule

// File: tb/sim_rst_pulse_gen.sv
module sim_rst_pulse_gen;
  localparam int CLK_PERIOD = 10;
  localparam int PRE = 3;
  localparam int STR = 4;
  localparam int WIN = PRE * STR;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b1, wdog_to = 1'b0, flag_set = 1'b0, flag_clr = 1'b0;
  logic rst_l, rst_h, flag_l, flag_h;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_pulse_gen #(.ACTIVE_LOW(1'b1), .PRESCALE(PRE), .STRETCH_TICKS(STR)) u0 (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .wdog_to(wdog_to),
    .flag_set(flag_set), .flag_clr(flag_clr), .rst_out(rst_l), .wd_flag(flag_l));
  rst_pulse_gen #(.ACTIVE_LOW(1'b0), .PRESCALE(PRE), .STRETCH_TICKS(STR)) u1 (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .wdog_to(wdog_to),
    .flag_set(flag_set), .flag_clr(flag_clr), .rst_out(rst_h), .wd_flag(flag_h));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // count negedges until release; polarity pair checked at the end
  task automatic measure(input string req, input int exp);
    int n = 0;
    while (rst_l == 1'b0 && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(n == exp, req, n, exp);
    chk(rst_h == 1'b0, "R5 high-polarity released", rst_h, 0);
  endtask

  task automatic step(); @(negedge clk); endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R3 power-on
    step(); step();
    chk(rst_l == 1'b0, "R3/R5 active-low in reset", rst_l, 0);
    chk(rst_h == 1'b1, "R3/R5 active-high in reset", rst_h, 1);
    chk(flag_l == 1'b0, "R3 flag cleared", flag_l, 0);
    rst_n = 1'b1;
    measure("R3 power-on stretch", WIN);

    // R1 held low supply keeps reset
    supply_ok = 1'b0;
    for (int i = 0; i < 5; i++) step();
    chk(rst_l == 1'b0 && rst_h == 1'b1, "R1 held while low", rst_l, 0);
    chk(flag_l == 1'b0, "R6 low supply clears flag", flag_l, 0);
    supply_ok = 1'b1;
    measure("R1/R2 release after low", WIN);

    // R2 dip at every window position, dip lengths 1..3
    for (int len = 1; len <= 3; len++) begin
      for (int k = 0; k < WIN; k++) begin
        supply_ok = 1'b0; step(); supply_ok = 1'b1;
        for (int j = 0; j < k; j++) step();
        chk(rst_l == 1'b0, "R2 still active before dip", rst_l, 0);
        supply_ok = 1'b0;
        for (int j = 0; j < len; j++) step();
        supply_ok = 1'b1;
        measure("R2 restart after dip", WIN);
      end
    end

    // R4 watchdog pulse, and at every window position
    wdog_to = 1'b1; step(); wdog_to = 1'b0;
    chk(rst_l == 1'b0, "R4 wdog asserts reset", rst_l, 0);
    chk(flag_l == 1'b1 && flag_h == 1'b1, "R6 wdog sets flag", flag_l, 1);
    measure("R4 wdog stretch", WIN);
    chk(flag_l == 1'b1, "R8 flag kept through release", flag_l, 1);
    for (int k = 0; k < WIN; k++) begin
      wdog_to = 1'b1; step(); wdog_to = 1'b0;
      for (int j = 0; j < k; j++) step();
      wdog_to = 1'b1; step(); wdog_to = 1'b0;
      measure("R4 restart by wdog in window", WIN);
    end

    // R6 both faults: low supply wins
    wdog_to = 1'b1; supply_ok = 1'b0; step(); wdog_to = 1'b0; supply_ok = 1'b1;
    chk(flag_l == 1'b0, "R6 low supply beats wdog", flag_l, 0);
    measure("R2 release after joint fault", WIN);

    // R7 commands
    flag_set = 1'b1; step(); flag_set = 1'b0;
    chk(flag_l == 1'b1, "R7 set command", flag_l, 1);
    chk(rst_l == 1'b1, "R7 set does not reset", rst_l, 1);
    for (int i = 0; i < 4; i++) step();
    chk(flag_l == 1'b1, "R8 flag holds idle", flag_l, 1);
    flag_clr = 1'b1; step(); flag_clr = 1'b0;
    chk(flag_l == 1'b0, "R7 clr command", flag_l, 0);
    flag_set = 1'b1; flag_clr = 1'b1; step(); flag_set = 1'b0; flag_clr = 1'b0;
    chk(flag_l == 1'b1, "R7 set wins over clr", flag_l, 1);
    flag_set = 1'b1; supply_ok = 1'b0; step(); flag_set = 1'b0; supply_ok = 1'b1;
    chk(flag_l == 1'b1, "R7 set beats low supply", flag_l, 1);
    measure("R2 release after command+fault", WIN);
    flag_clr = 1'b1; wdog_to = 1'b1; step(); flag_clr = 1'b0; wdog_to = 1'b0;
    chk(flag_l == 1'b0, "R7 clr beats wdog", flag_l, 0);
    measure("R4 release after command+wdog", WIN);

    // R3 reset mid-operation
    flag_set = 1'b1; step(); flag_set = 1'b0;
    rst_n = 1'b0; step();
    chk(flag_l == 1'b0 && rst_l == 1'b0, "R3 reset clears flag, asserts", flag_l, 0);
    rst_n = 1'b1;
    measure("R3 re-power stretch", WIN);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule